// File: doc/BRIEF.md
# Memory Write Protection Controller

This block sits beside a 256-byte non-volatile memory and rules on every pending byte write: it answers each write request with either a grant or a refusal one clock later. The answer depends on a hardware protect pin and on two protection flags that the block keeps itself. A permanent flag can only ever be set. A reversible flag can be set or cleared, but only under a test condition: a high voltage sensed on the A0 strap pin, together with fixed logic levels on the A1 and A2 straps. Either flag guards only the lower half of the memory.

Flag commands arrive as single-cycle strobes. Each is answered one cycle later with an acknowledge or a refusal. A refused command leaves both flags as they were. The serial front end can also read the flag state. It does this with a status request that carries the 4-bit device-type code of the address byte. Only the status code yields a reply. The reply byte holds the inverted flags in its two lowest bits and zeros above them. The memory side uses the grant to decide whether it starts an internal write cycle. A refused write is still acknowledged on the serial bus but writes nothing.

Top module: `wp_guard`

## Requirements
- R1: After a synchronous active-low reset, both flags are clear, all reply outputs are 0, and a status read returns 8'h03.
- R2: While `prot_pin` is 1, every write request is answered with `wr_deny`=1 and `wr_allow`=0, whatever the address or flags.
- R3: While `prot_pin` is 1, every flag command is answered with `cmd_nak`, and neither flag changes.
- R4: With `prot_pin` at 0 and both flags clear, a write to any address 0..255 is answered with `wr_allow`.
- R5: With `prot_pin` at 0 and either flag set, a write to addresses 0..127 (address bit 7 = 0) is denied, and a write to 128..255 is allowed.
- R6: `cmd_set_perm` with `prot_pin` at 0 sets the permanent flag and is acknowledged. No command clears that flag: a reversible-flag clear leaves it set.
- R7: `cmd_set_rev` and `cmd_clr_rev` are acknowledged and take effect only when `hv_on_a0`=1, `strap_a1`=0 and `strap_a2`=1. Otherwise they are refused and the flags do not change.
- R8: `stat_req` with `stat_code`=4'b0110 gives `stat_vld`=1 one cycle later. The byte is then {6'b0, ~reversible, ~permanent}: bit 0 is the inverted permanent flag and bit 1 is the inverted reversible flag. With any other code, no reply is given.
- R9: Every write request and every flag command gets exactly one reply, in the cycle after the request. The reply is `wr_allow` or `wr_deny` for a write, and `cmd_ack` or `cmd_nak` for a command. When there is no request, no reply is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_pin | input | 1 | Hardware protect level, 1 = protect all |
| wr_req | input | 1 | Pending byte write strobe |
| wr_addr | input | 8 | Target byte address of the write |
| cmd_set_perm | input | 1 | Set-permanent-flag command strobe |
| cmd_set_rev | input | 1 | Set-reversible-flag command strobe |
| cmd_clr_rev | input | 1 | Clear-reversible-flag command strobe |
| hv_on_a0 | input | 1 | High voltage sensed on the A0 strap |
| strap_a1 | input | 1 | A1 strap logic level |
| strap_a2 | input | 1 | A2 strap logic level |
| stat_req | input | 1 | Status read request strobe |
| stat_code | input | 4 | Device-type code of the read |
| wr_allow | output | 1 | Write granted |
| wr_deny | output | 1 | Write refused |
| cmd_ack | output | 1 | Flag command accepted |
| cmd_nak | output | 1 | Flag command refused |
| stat_vld | output | 1 | Status byte valid |
| stat_byte | output | 8 | Flag status byte |

## Verification
The assertions assume that at most one of the three flag command strobes is high in any cycle. They also assume that the straps and the high-voltage indication are sampled only in the cycle of a command, so those inputs may change freely at other times. The stimulus keeps within these limits by issuing one request per cycle, a write or a command or a status read, never two together. The strap and high-voltage levels are set in the same cycle as the command that uses them.

// File: rtl/wpg_pkg.sv
// Shared types for the write protection controller.
// Assumes: at most one flag command strobe is active per cycle.
package wpg_pkg;

    // Stored protection flags
    typedef struct packed {
        logic perm;   // set-only flag
        logic rev;    // reversible flag
    } wpg_flags_t;

    // Flag command decoded from the strobes
    typedef enum logic [1:0] {
        WPG_NOP      = 2'd0,
        WPG_SET_PERM = 2'd1,
        WPG_SET_REV  = 2'd2,
        WPG_CLR_REV  = 2'd3
    } wpg_op_e;

    // Turns the command strobes into one operation (fixed priority if misused)
    function automatic wpg_op_e wpg_decode(input logic sp, input logic sr, input logic cr);
        wpg_op_e op;
        if (sp)      op = WPG_SET_PERM;
        else if (sr) op = WPG_SET_REV;
        else if (cr) op = WPG_CLR_REV;
        else         op = WPG_NOP;
        return op;
    endfunction

endpackage

// File: rtl/wpg_flag_store.sv
// Holds the two protection flags and rules on flag commands.
// The permanent flag is set-only. The reversible flag changes only under
// high voltage on A0 with the A1/A2 straps at REV_A1/REV_A2. The protect
// pin refuses all commands. Each command gets one ack or nak a cycle later.
// Assumes: op is valid only for the single cycle of the request.
module wpg_flag_store
    import wpg_pkg::*;
#(
    parameter logic REV_A1 = 1'b0,
    parameter logic REV_A2 = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prot_pin,
    input  wpg_op_e    op,
    input  logic       hv_on_a0,
    input  logic       strap_a1,
    input  logic       strap_a2,
    output wpg_flags_t flags,
    output logic       cmd_ack,
    output logic       cmd_nak
);

    logic       rev_key;
    logic       granted;
    wpg_flags_t flags_nxt;

    // Reversible-flag unlock condition from the straps
    always_comb begin
        rev_key = hv_on_a0 && (strap_a1 == REV_A1) && (strap_a2 == REV_A2);
    end

    // Grant decision and next flag state for the current command
    always_comb begin
        granted   = 1'b0;
        flags_nxt = flags;
        unique case (op)
            WPG_SET_PERM: begin
                granted = !prot_pin;
                if (granted) flags_nxt.perm = 1'b1;
            end
            WPG_SET_REV: begin
                granted = !prot_pin && rev_key;
                if (granted) flags_nxt.rev = 1'b1;
            end
            WPG_CLR_REV: begin
                granted = !prot_pin && rev_key;
                if (granted) flags_nxt.rev = 1'b0;
            end
            default: granted = 1'b0;
        endcase
    end

    // Flag register and command reply register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            cmd_ack <= 1'b0;
            cmd_nak <= 1'b0;
        end else begin
            flags   <= flags_nxt;
            cmd_ack <= (op != WPG_NOP) && granted;
            cmd_nak <= (op != WPG_NOP) && !granted;
        end
    end

    // R6: once set, the permanent flag stays set until reset
    assert_perm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags.perm |=> flags.perm);

    // R3: the protect pin freezes both flags and refuses any command
    assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prot_pin |=> $stable(flags));
    assert_lock_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_pin && op != WPG_NOP) |=> (cmd_nak && !cmd_ack));

    // R7: reversible-flag commands without high voltage are refused and change nothing
    assert_rev_needs_hv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == WPG_SET_REV || op == WPG_CLR_REV) && !hv_on_a0) |=> (cmd_nak && $stable(flags.rev)));

    // R9: never both replies at once, and no reply without a command
    assert_one_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ack && cmd_nak));
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WPG_NOP) |=> !(cmd_ack || cmd_nak));

endmodule

// File: rtl/wpg_write_gate.sv
// Rules on each pending byte write. The protect pin blocks every address.
// Either flag blocks the lower half of the address space (MSB = 0).
// Replies with a one-cycle allow or deny pulse after the request.
// Assumes: wr_addr is valid in the cycle wr_req is high.
module wpg_write_gate
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_pin,
    input  wpg_flags_t        flags,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_allow,
    output logic              wr_deny
);

    localparam int TOP_BIT = ADDR_W - 1;

    logic low_half;
    logic blocked;

    // Protection verdict for the presented address
    always_comb begin
        low_half = !wr_addr[TOP_BIT];
        blocked  = prot_pin || (low_half && (flags.perm || flags.rev));
    end

    // Registered verdict, one pulse per request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_allow <= 1'b0;
            wr_deny  <= 1'b0;
        end else begin
            wr_allow <= wr_req && !blocked;
            wr_deny  <= wr_req && blocked;
        end
    end

    // R2: the protect pin denies every write
    assert_pin_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && prot_pin) |=> (wr_deny && !wr_allow));

    // R5: a flag guards the lower half only
    assert_low_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_addr[TOP_BIT] && (flags.perm || flags.rev)) |=> wr_deny);
    assert_high_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr[TOP_BIT] && !prot_pin) |=> wr_allow);

    // R4: with no protection at all, every write is allowed
    assert_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !prot_pin && !flags.perm && !flags.rev) |=> wr_allow);

    // R9: exactly one reply per request, none otherwise
    assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (wr_allow != wr_deny));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !(wr_allow || wr_deny));

endmodule

// File: rtl/wpg_status_port.sv
// Answers a status read that carries the status device-type code.
// Returns the inverted flags in the two low bits and zeros above them.
// Other codes get no reply.
// Assumes: stat_code is valid in the cycle stat_req is high.
module wpg_status_port
    import wpg_pkg::*;
#(
    parameter int         STAT_W    = 8,
    parameter logic [3:0] STAT_CODE = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_req,
    input  logic [3:0]        stat_code,
    input  wpg_flags_t        flags,
    output logic              stat_vld,
    output logic [STAT_W-1:0] stat_byte
);

    localparam int PAD_W = STAT_W - 2;

    logic hit;

    // Match the status device-type code
    always_comb begin
        hit = stat_req && (stat_code == STAT_CODE);
    end

    // Register the reply byte with inverted flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_vld  <= 1'b0;
            stat_byte <= '0;
        end else begin
            stat_vld  <= hit;
            stat_byte <= hit ? {{PAD_W{1'b0}}, ~flags.rev, ~flags.perm} : '0;
        end
    end

    // R8: upper bits are zero and a reply follows only a matching request
    assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (stat_byte[STAT_W-1:2] == '0));
    assert_code_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_req && stat_code != STAT_CODE) |=> !stat_vld);
    assert_inverted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (stat_vld && stat_byte[1:0] == ~{$past(flags.rev), $past(flags.perm)}));

endmodule

// File: rtl/wp_guard.sv
// Top of the write protection controller. It joins the flag store, the
// write gate and the status port. Every reply is registered one cycle
// after its request.
// Assumes: one flag command strobe at most per cycle. Straps and the
// high-voltage indication are meaningful in the command cycle only.
module wp_guard
    import wpg_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         STAT_W    = 8,
    parameter logic [3:0] STAT_CODE = 4'b0110,
    parameter logic       REV_A1    = 1'b0,
    parameter logic       REV_A2    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_pin,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              cmd_set_perm,
    input  logic              cmd_set_rev,
    input  logic              cmd_clr_rev,
    input  logic              hv_on_a0,
    input  logic              strap_a1,
    input  logic              strap_a2,
    input  logic              stat_req,
    input  logic [3:0]        stat_code,
    output logic              wr_allow,
    output logic              wr_deny,
    output logic              cmd_ack,
    output logic              cmd_nak,
    output logic              stat_vld,
    output logic [STAT_W-1:0] stat_byte
);

    wpg_op_e    op;
    wpg_flags_t flags;

    // Decode the command strobes
    always_comb begin
        op = wpg_decode(cmd_set_perm, cmd_set_rev, cmd_clr_rev);
    end

    wpg_flag_store #(
        .REV_A1 (REV_A1),
        .REV_A2 (REV_A2)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot_pin (prot_pin),
        .op       (op),
        .hv_on_a0 (hv_on_a0),
        .strap_a1 (strap_a1),
        .strap_a2 (strap_a2),
        .flags    (flags),
        .cmd_ack  (cmd_ack),
        .cmd_nak  (cmd_nak)
    );

    wpg_write_gate #(
        .ADDR_W (ADDR_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot_pin (prot_pin),
        .flags    (flags),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_allow (wr_allow),
        .wr_deny  (wr_deny)
    );

    wpg_status_port #(
        .STAT_W    (STAT_W),
        .STAT_CODE (STAT_CODE)
    ) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_req  (stat_req),
        .stat_code (stat_code),
        .flags     (flags),
        .stat_vld  (stat_vld),
        .stat_byte (stat_byte)
    );

    // R9: input rule, one flag command per cycle at most
    assert_one_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_set_perm, cmd_set_rev, cmd_clr_rev}));

    // R1: replies are quiet in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !(wr_allow || wr_deny || cmd_ack || cmd_nak || stat_vld));

endmodule

// File: tb/wp_guard_test.sv
// Scoreboard bench: driver tasks push the expected reply vector, and a
// monitor pops and compares it one cycle after each request.
module wp_guard_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prot_pin = 1'b0;
    logic       wr_req = 1'b0;
    logic [7:0] wr_addr = '0;
    logic       cmd_set_perm = 1'b0, cmd_set_rev = 1'b0, cmd_clr_rev = 1'b0;
    logic       hv_on_a0 = 1'b0, strap_a1 = 1'b0, strap_a2 = 1'b0;
    logic       stat_req = 1'b0;
    logic [3:0] stat_code = '0;
    logic       wr_allow, wr_deny, cmd_ack, cmd_nak, stat_vld;
    logic [7:0] stat_byte;

    typedef struct {
        string      tag;
        logic [12:0] exp;
    } item_t;

    item_t queue_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    m_perm = 1'b0, m_rev = 1'b0;

    wp_guard uut (
        .clk(clk), .rst_n(rst_n), .prot_pin(prot_pin),
        .wr_req(wr_req), .wr_addr(wr_addr),
        .cmd_set_perm(cmd_set_perm), .cmd_set_rev(cmd_set_rev), .cmd_clr_rev(cmd_clr_rev),
        .hv_on_a0(hv_on_a0), .strap_a1(strap_a1), .strap_a2(strap_a2),
        .stat_req(stat_req), .stat_code(stat_code),
        .wr_allow(wr_allow), .wr_deny(wr_deny), .cmd_ack(cmd_ack), .cmd_nak(cmd_nak),
        .stat_vld(stat_vld), .stat_byte(stat_byte)
    );

    always #4 clk = ~clk;

    function automatic logic [12:0] reply_vec();
        return {wr_allow, wr_deny, cmd_ack, cmd_nak, stat_vld, stat_byte};
    endfunction

    // Monitor: compare the reply one cycle after the request
    always @(posedge clk) begin
        #1;
        if (queue_q.size() > 0) begin
            item_t it;
            it = queue_q.pop_front();
            n_cmp++;
            if (reply_vec() !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %b expected %b", it.tag, reply_vec(), it.exp);
            end
        end
    end

    task automatic clear_inputs();
        wr_req = 0; cmd_set_perm = 0; cmd_set_rev = 0; cmd_clr_rev = 0; stat_req = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input string tag);
        logic ok;
        @(negedge clk);
        clear_inputs();
        wr_req = 1; wr_addr = a;
        ok = !prot_pin && !(a < 8'd128 && (m_perm || m_rev));
        queue_q.push_back('{tag, {ok, !ok, 11'b0}});
    endtask

    // kind: 0 set perm, 1 set rev, 2 clear rev
    task automatic do_cmd(input int kind, input logic hv, input logic a1, input logic a2, input string tag);
        logic ok;
        @(negedge clk);
        clear_inputs();
        hv_on_a0 = hv; strap_a1 = a1; strap_a2 = a2;
        if (kind == 0) cmd_set_perm = 1;
        else if (kind == 1) cmd_set_rev = 1;
        else cmd_clr_rev = 1;
        if (kind == 0) ok = !prot_pin;
        else ok = !prot_pin && hv && !a1 && a2;
        if (ok) begin
            if (kind == 0) m_perm = 1;
            else if (kind == 1) m_rev = 1;
            else m_rev = 0;
        end
        queue_q.push_back('{tag, {2'b00, ok, !ok, 9'b0}});
    endtask

    task automatic do_stat(input logic [3:0] code, input string tag);
        @(negedge clk);
        clear_inputs();
        stat_req = 1; stat_code = code;
        if (code == 4'b0110)
            queue_q.push_back('{tag, {4'b0, 1'b1, 6'b0, ~m_rev, ~m_perm}});
        else
            queue_q.push_back('{tag, 13'b0});
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        clear_inputs();
        queue_q.push_back('{tag, 13'b0});
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        if (reply_vec() !== 13'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: actual %b expected %b", reply_vec(), 13'b0);
        end
        rst_n = 1;
        do_stat(4'b0110, "R1 status after reset");
        // R4: no protection, every address writable
        do_write(8'h00, "R4 addr 0x00");
        do_write(8'h7F, "R4 addr 0x7F");
        do_write(8'h80, "R4 addr 0x80");
        do_write(8'hFF, "R4 addr 0xFF");
        do_idle("R9 idle no reply");
        // R2/R3: protect pin
        @(negedge clk); prot_pin = 1;
        do_write(8'h10, "R2 pin blocks low");
        do_write(8'h90, "R2 pin blocks high");
        do_cmd(0, 0, 0, 1, "R3 set perm refused");
        do_cmd(1, 1, 0, 1, "R3 set rev refused");
        do_stat(4'b0110, "R3 flags unchanged");
        @(negedge clk); prot_pin = 0;
        // R7: unlock condition
        do_cmd(1, 0, 0, 1, "R7 no hv");
        do_cmd(1, 1, 1, 1, "R7 wrong a1");
        do_cmd(1, 1, 0, 0, "R7 wrong a2");
        do_stat(4'b0110, "R7 flags unchanged");
        do_cmd(1, 1, 0, 1, "R7 set rev ok");
        do_stat(4'b0110, "R8 rev set reads 0x01");
        // R5: lower half guarded
        do_write(8'h7F, "R5 rev blocks 0x7F");
        do_write(8'h80, "R5 rev frees 0x80");
        do_write(8'h00, "R5 rev blocks 0x00");
        do_cmd(2, 0, 0, 1, "R7 clear no hv");
        do_stat(4'b0110, "R7 rev kept");
        do_cmd(2, 1, 0, 1, "R7 clear ok");
        do_stat(4'b0110, "R7 rev cleared");
        do_write(8'h00, "R4 reopened 0x00");
        // R6: permanent flag
        do_cmd(0, 0, 0, 0, "R6 set perm");
        do_stat(4'b0110, "R6 perm reads 0x02");
        do_write(8'h7F, "R5 perm blocks 0x7F");
        do_write(8'hFF, "R5 perm frees 0xFF");
        do_cmd(2, 1, 0, 1, "R6 rev clear keeps perm");
        do_stat(4'b0110, "R6 perm still set");
        do_write(8'h05, "R6 still blocks 0x05");
        do_cmd(0, 0, 0, 0, "R6 set perm again");
        // R8: other device codes give no status
        do_stat(4'b1010, "R8 memory code no reply");
        do_stat(4'b0111, "R8 other code no reply");
        // R2 overrides the high half too
        @(negedge clk); clear_inputs(); prot_pin = 1;
        queue_q.push_back('{"R9 idle", 13'b0});
        do_write(8'hFF, "R2 pin blocks 0xFF");
        do_idle("R9 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule